// File: doc/BRIEF.md
# Quantized Dot-Product Multiply-Accumulate Engine

This block forms the dot product of two vectors whose elements are 8-bit unsigned quantized values (0 to 255). Element pairs, one activation and one weight, arrive one per transfer on a valid/ready stream, and a last flag marks the final pair of a vector. Each pair is multiplied into a 32-bit unsigned product. The product is then added to the running total by a multi-cycle adder that works by repeated carry-shift steps. The same engine serves a flattened convolution patch against a flattened kernel and a fully connected row against a weight column; only the vector length differs.

The carry-shift adder starts with the XOR of its operands as a partial sum and the shifted AND as a carry. While the carry is nonzero it repeats the XOR/AND-shift step, up to a fixed iteration bound. If the carry is still nonzero after the bound, the adder finishes with an ordinary binary addition and flags that it took this fallback path. The engine stalls its input while an addition is in flight. When the last addition of a vector completes, it presents the 32-bit total for one cycle. With the total come the number of additions in that vector that used the fallback, and the fixed rescale divisor 255*255 that a later stage uses to return to real values. No bias term is ever added.

Top module: `qdot_mac_engine`

## Requirements
- R1: `in_ready` is high only while the engine is idle. In the cycle after a pair is accepted (`in_valid` and `in_ready` both high at a clock edge) it is low, and it stays low while the adder is busy.
- R2: Each accepted pair contributes the unsigned product `in_act * in_wgt`, zero-extended to 32 bits. A one-element vector therefore returns exactly that product.
- R3: The running total is cleared when the first pair of a vector is accepted. The first pair is the first after reset or the first after a pair with `in_last` high. The reported total is the sum of that vector's products modulo 2^32, with no bias and nothing carried over from earlier vectors.
- R4: Each addition of running total A and product P works as follows. It sets S = A xor P and C = (A and P) << 1. While C is nonzero and fewer than 5 steps have run, it replaces S with S xor C and C with (S and C) << 1 (the old S is used in both). If C is still nonzero after 5 steps, it returns S + C and counts one fallback. Every addition returns the exact sum either way. `out_fb_cnt` reports the number of fallbacks within the finished vector.
- R5: `out_valid` is high for exactly one cycle per vector, the cycle after the addition of the last pair completes. `out_sum` and `out_fb_cnt` change only in that cycle and hold their values otherwise.
- R6: `out_scale` always equals 65025 (255*255).
- R7: After reset, `in_ready` is 1, `out_valid` is 0, `out_sum` is 0 and `out_fb_cnt` is 0.
- R8: Vectors of any length from 1 to 1024 pairs are supported, and `out_fb_cnt` never exceeds 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An element pair is offered |
| in_ready | output | 1 | Engine accepts a pair at this edge |
| in_last | input | 1 | The offered pair ends its vector |
| in_act | input | 8 | Quantized activation, 0 to 255 |
| in_wgt | input | 8 | Quantized weight, 0 to 255 |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | 32 | Accumulated dot product (integer) |
| out_scale | output | 32 | Rescale divisor, fixed at 65025 |
| out_fb_cnt | output | 11 | Fallback additions in the finished vector |

## Verification
The bench aims at the boundary between the carry-shift steps and the fallback. It sends all-255 vectors and long random vectors so that carry chains run past the iteration bound. An engine that stops at the wrong step count, or drops the final carry, reports a wrong total or a wrong fallback count. One-element vectors right after multi-element ones check that the total clears at a vector start; an engine that leaked the previous total would return the wrong sum. Random gaps between offers, and a 1024-element vector, show whether the stall and the one-cycle strobe keep their cycle timing. A design that accepted a pair while busy would lose or double-count products.

// File: rtl/qdot_pkg.sv
package qdot_pkg;

  // Sequencer phases: waiting for a pair, launching the add, waiting for it.
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;

  // Divisor that maps a sum of two-operand products back to real scale.
  function automatic int unsigned rescale_of(input int unsigned dw);
    return ((32'd1 << dw) - 32'd1) * ((32'd1 << dw) - 32'd1);
  endfunction

endpackage

// File: rtl/qdot_mul.sv
module qdot_mul #(
  parameter int DW = 8,
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [PW-1:0] prod
);

  logic [PW-1:0] prod_d;
  logic [PW-1:0] prod_q;

  always_comb begin
    prod_d = prod_q;
    if (en) prod_d = PW'(a) * PW'(b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign prod = prod_q;

endmodule

// File: rtl/qdot_cs_adder.sv
module qdot_cs_adder #(
  parameter int W        = 32,
  parameter int MAX_ITER = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sum,
  output logic         fallback
);

  localparam int ITW = $clog2(MAX_ITER + 1);

  logic [W-1:0]   s_q, s_d;
  logic [W-1:0]   c_q, c_d;
  logic [ITW-1:0] it_q, it_d;
  logic           busy_q, busy_d;
  logic           done_q, done_d;
  logic [W-1:0]   res_q, res_d;
  logic           fb_q, fb_d;

  always_comb begin
    s_d    = s_q;
    c_d    = c_q;
    it_d   = it_q;
    busy_d = busy_q;
    done_d = 1'b0;
    res_d  = res_q;
    fb_d   = fb_q;
    if (start && !busy_q) begin
      s_d    = a ^ b;
      c_d    = (a & b) << 1;
      it_d   = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (c_q == '0) begin
        res_d  = s_q;
        fb_d   = 1'b0;
        done_d = 1'b1;
        busy_d = 1'b0;
      end else if (it_q == ITW'(MAX_ITER)) begin
        res_d  = s_q + c_q;
        fb_d   = 1'b1;
        done_d = 1'b1;
        busy_d = 1'b0;
      end else begin
        s_d  = s_q ^ c_q;
        c_d  = (s_q & c_q) << 1;
        it_d = it_q + ITW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q    <= '0;
      c_q    <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
      fb_q   <= 1'b0;
    end else begin
      s_q    <= s_d;
      c_q    <= c_d;
      it_q   <= it_d;
      busy_q <= busy_d;
      done_q <= done_d;
      res_q  <= res_d;
      fb_q   <= fb_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign sum      = res_q;
  assign fallback = fb_q;

endmodule

// File: rtl/qdot_seq.sv
module qdot_seq
  import qdot_pkg::*;
#(
  parameter int ACCW = 32,
  parameter int CNTW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_last,
  output logic            in_ready,
  output logic            mul_en,
  output logic            add_start,
  output logic [ACCW-1:0] add_a,
  input  logic            add_done,
  input  logic [ACCW-1:0] add_res,
  input  logic            add_fb,
  output logic            out_valid,
  output logic [ACCW-1:0] out_sum,
  output logic [CNTW-1:0] out_fb_cnt
);

  sq_state_t       st_q, st_d;
  logic            open_q, open_d;   // next pair starts a new vector
  logic            head_q, head_d;   // current pair is the first of its vector
  logic            last_q, last_d;
  logic [ACCW-1:0] acc_q, acc_d;
  logic [CNTW-1:0] fb_q, fb_d;
  logic            ov_q, ov_d;
  logic [ACCW-1:0] osum_q, osum_d;
  logic [CNTW-1:0] ofb_q, ofb_d;
  logic            accept;

  assign in_ready = (st_q == SQ_IDLE);
  assign accept   = in_valid && in_ready;
  assign mul_en   = accept;
  assign add_a    = head_q ? '0 : acc_q;

  always_comb begin
    st_d      = st_q;
    open_d    = open_q;
    head_d    = head_q;
    last_d    = last_q;
    acc_d     = acc_q;
    fb_d      = fb_q;
    ov_d      = 1'b0;
    osum_d    = osum_q;
    ofb_d     = ofb_q;
    add_start = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (accept) begin
          head_d = open_q;
          last_d = in_last;
          open_d = in_last;
          st_d   = SQ_ISSUE;
        end
      end
      SQ_ISSUE: begin
        add_start = 1'b1;
        st_d      = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (add_done) begin
          acc_d = add_res;
          fb_d  = (head_q ? '0 : fb_q) + CNTW'(add_fb);
          if (last_q) begin
            ov_d   = 1'b1;
            osum_d = add_res;
            ofb_d  = fb_d;
          end
          st_d = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      open_q <= 1'b1;
      head_q <= 1'b1;
      last_q <= 1'b0;
      acc_q  <= '0;
      fb_q   <= '0;
      ov_q   <= 1'b0;
      osum_q <= '0;
      ofb_q  <= '0;
    end else begin
      st_q   <= st_d;
      open_q <= open_d;
      head_q <= head_d;
      last_q <= last_d;
      acc_q  <= acc_d;
      fb_q   <= fb_d;
      ov_q   <= ov_d;
      osum_q <= osum_d;
      ofb_q  <= ofb_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_sum    = osum_q;
  assign out_fb_cnt = ofb_q;

endmodule

// File: rtl/qdot_mac_engine.sv
module qdot_mac_engine
  import qdot_pkg::*;
#(
  parameter int DW       = 8,
  parameter int ACCW     = 32,
  parameter int MAX_ITER = 5,
  parameter int MAX_LEN  = 1024,
  localparam int CNTW    = $clog2(MAX_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_last,
  input  logic [DW-1:0]   in_act,
  input  logic [DW-1:0]   in_wgt,
  output logic            out_valid,
  output logic [ACCW-1:0] out_sum,
  output logic [ACCW-1:0] out_scale,
  output logic [CNTW-1:0] out_fb_cnt
);

  localparam int unsigned SCALE = rescale_of(DW);

  logic            mul_en;
  logic [ACCW-1:0] prod;
  logic            add_start;
  logic [ACCW-1:0] add_a;
  logic            add_busy;
  logic            add_done;
  logic [ACCW-1:0] add_res;
  logic            add_fb;

  qdot_mul #(.DW(DW), .PW(ACCW)) i_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (mul_en),
    .a    (in_act),
    .b    (in_wgt),
    .prod (prod)
  );

  qdot_cs_adder #(.W(ACCW), .MAX_ITER(MAX_ITER)) i_add (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (add_start),
    .a       (add_a),
    .b       (prod),
    .busy    (add_busy),
    .done    (add_done),
    .sum     (add_res),
    .fallback(add_fb)
  );

  qdot_seq #(.ACCW(ACCW), .CNTW(CNTW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .mul_en    (mul_en),
    .add_start (add_start),
    .add_a     (add_a),
    .add_done  (add_done),
    .add_res   (add_res),
    .add_fb    (add_fb),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_fb_cnt(out_fb_cnt)
  );

  assign out_scale = ACCW'(SCALE);

endmodule

// File: rtl/qdot_mac_engine_chk.sv
module qdot_mac_engine_chk #(
  parameter int ACCW    = 32,
  parameter int CNTW    = 11,
  parameter int MAX_LEN = 1024
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic [ACCW-1:0] out_sum,
  input logic [CNTW-1:0] out_fb_cnt,
  input logic            add_start,
  input logic [ACCW-1:0] add_a,
  input logic [ACCW-1:0] add_b,
  input logic            add_busy,
  input logic            add_done,
  input logic [ACCW-1:0] add_res
);

  logic [ACCW-1:0] want_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         want_q <= '0;
    else if (add_start) want_q <= add_a + add_b;
  end

  // R1
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_busy |-> !in_ready);

  // R1
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4
  adder_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_done |-> (add_res == want_q));

  // R5
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out_sum) || !$stable(out_fb_cnt)) |-> out_valid);

  // R8
  fb_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fb_cnt <= CNTW'(MAX_LEN));

endmodule

bind qdot_mac_engine qdot_mac_engine_chk #(
  .ACCW(ACCW), .CNTW(CNTW), .MAX_LEN(MAX_LEN)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_sum   (out_sum),
  .out_fb_cnt(out_fb_cnt),
  .add_start (add_start),
  .add_a     (add_a),
  .add_b     (prod),
  .add_busy  (add_busy),
  .add_done  (add_done),
  .add_res   (add_res)
);

// File: tb/test_qdot_mac_engine.sv
module test_qdot_mac_engine;

  localparam int CLK_PERIOD = 10;
  localparam int CNTW = 11;

  typedef struct {
    logic [31:0] sum;
    int          fb;
    string       tag;
  } exp_t;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic            in_last;
  logic [7:0]      in_act;
  logic [7:0]      in_wgt;
  logic            out_valid;
  logic [31:0]     out_sum;
  logic [31:0]     out_scale;
  logic [CNTW-1:0] out_fb_cnt;

  exp_t exp_q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  int   n_sent = 0;
  int   n_seen = 0;
  bit   done_f = 0;

  qdot_mac_engine i_qdot_mac_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt),
    .out_valid(out_valid), .out_sum(out_sum), .out_scale(out_scale),
    .out_fb_cnt(out_fb_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // R4 reference: does adding a and b fall back after 5 carry-shift steps
  function automatic bit needs_fallback(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s, c, t;
    s = a ^ b;
    c = (a & b) << 1;
    for (int k = 0; k < 5 && c != 0; k++) begin
      t = s;
      s = t ^ c;
      c = (t & c) << 1;
    end
    return c != 0;
  endfunction

  task automatic send_pair(input logic [7:0] a, input logic [7:0] w, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_act = a; in_wgt = w; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_act = $urandom; in_wgt = $urandom; in_last = $urandom;
  endtask

  // Driver: compute the expected result, queue it, then stream the pairs.
  task automatic run_vec(input logic [7:0] av[], input logic [7:0] wv[],
                         input string tag, input bit gaps);
    exp_t        e;
    logic [31:0] acc;
    logic [31:0] p;
    acc = 0; e.fb = 0;
    foreach (av[i]) begin
      p = 32'(av[i]) * 32'(wv[i]);
      if (needs_fallback(acc, p)) e.fb++;
      acc = acc + p;
    end
    e.sum = acc; e.tag = tag;
    exp_q.push_back(e);
    n_sent++;
    foreach (av[i]) begin
      if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
      send_pair(av[i], wv[i], i == av.size() - 1);
    end
  endtask

  // Monitor: scoreboard compare plus handshake timing (R1, R5, R6).
  bit prev_acc = 0;
  bit prev_ov  = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_acc) check(!in_ready, "R1", "ready after accept", in_ready, 0);
      if (prev_ov && out_valid) check(0, "R5", "strobe longer than one cycle", 1, 0);
      if (out_valid) begin
        n_seen++;
        if (exp_q.size() == 0) begin
          check(0, "R5", "unexpected result strobe", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(out_sum == e.sum, e.tag, "sum", out_sum, e.sum);
          check(int'(out_fb_cnt) == e.fb, "R4", "fallback count", out_fb_cnt, e.fb);
          check(out_scale == 32'd65025, "R6", "scale", out_scale, 65025);
        end
      end
      prev_acc = in_valid && in_ready;
      prev_ov  = out_valid;
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done_f) begin
      check(0, "R1", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] a[];
    logic [7:0] w[];
    logic [31:0] held;
    in_valid = 0; in_last = 0; in_act = 0; in_wgt = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    check(in_ready == 1'b1, "R7", "in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R7", "out_valid", out_valid, 0);
    check(out_sum == 0, "R7", "out_sum", out_sum, 0);
    check(out_fb_cnt == 0, "R7", "out_fb_cnt", out_fb_cnt, 0);
    check(out_scale == 32'd65025, "R6", "scale at reset", out_scale, 65025);

    // R2 single-element vectors
    a = new[1]; w = new[1];
    a[0] = 8'd255; w[0] = 8'd255; run_vec(a, w, "R2", 0);
    a[0] = 8'd0;   w[0] = 8'd173; run_vec(a, w, "R2", 0);
    a[0] = 8'd1;   w[0] = 8'd1;   run_vec(a, w, "R2", 0);

    // R3 short vectors back to back, then a single one (clear check)
    a = new[3]; w = new[3];
    a = '{8'd255, 8'd255, 8'd255}; w = '{8'd255, 8'd255, 8'd255};
    run_vec(a, w, "R3", 0);
    a = '{8'd12, 8'd200, 8'd7}; w = '{8'd3, 8'd99, 8'd250};
    run_vec(a, w, "R3", 1);
    a = new[1]; w = new[1];
    a[0] = 8'd2; w[0] = 8'd3; run_vec(a, w, "R3", 0);

    // R4 random vectors with varied gaps, long carry chains
    for (int v = 0; v < 12; v++) begin
      int n;
      n = $urandom_range(2, 40);
      a = new[n]; w = new[n];
      foreach (a[i]) begin
        a[i] = (v % 3 == 0) ? 8'd255 : 8'($urandom);
        w[i] = (v % 3 == 0) ? 8'($urandom_range(240, 255)) : 8'($urandom);
      end
      run_vec(a, w, "R4", v % 2 == 1);
    end

    // R8 maximum length vector, all 255
    a = new[1024]; w = new[1024];
    foreach (a[i]) begin a[i] = 8'd255; w[i] = 8'd255; end
    run_vec(a, w, "R8", 0);

    // drain
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, "R5", "results outstanding", exp_q.size(), 0);
    check(n_seen == n_sent, "R5", "result count", n_seen, n_sent);

    // R5 outputs hold with no traffic
    held = out_sum;
    repeat (10) @(negedge clk);
    check(out_sum == held && !out_valid, "R5", "hold while idle", out_sum, held);

    done_f = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule